// File: doc/BRIEF.md
# Programmable Control Decoder Array with Cycle Sequencer

This block is the control decoder of a small microprocessor. It is built as a two-plane programmable logic array. Its inputs are the instruction register, the current machine-cycle state, the status flags, the two interrupt request lines and the memory-ready line. Each input reaches the AND plane twice, once as a true line and once as a complemented line. Product terms are formed in the AND plane, and the OR plane gathers chosen terms into a wide bank of control lines.

The lowest control lines form the next-state field of a small cycle-sequencer register, and that register is itself an array input. Each machine cycle can therefore branch straight to the cycle that should follow it. The control lines are Mealy outputs: they change in the same cycle as the live inputs and the present state.

Both planes are loaded through a synchronous write port, one AND-plane row or one OR-plane column per clock. The number of product terms is a parameter of its own. The defaults give 21 array inputs (42 AND-plane lines), 130 control lines and a 4-bit state that can count up to seven cycles.

Top module: `pla_ctrl_decoder`

## Requirements
- R1: The array input vector, from bit 0 upward, is ir_i, then the sequencer state, then status_i[5:0], then irq_i, then nmi_i, then rdy_i. The default parameters give 21 inputs.
- R2: In an AND-plane row, bit 2k set requires input k to be 1 and bit 2k+1 set requires input k to be 0. The product term is 1 exactly when all of its required literals hold.
- R3: A product term whose row has no bits set evaluates to 1 for every input.
- R4: A product term that requires both polarities of the same input evaluates to 0 for every input.
- R5: Control line j is 1 exactly when some product term t is 1 and bit t of OR-plane column j is set.
- R6: ctrl_o is a combinational function of the present state and the live inputs, valid in the same cycle with no register delay.
- R7: A write with cfg_plane_i=0 loads AND row cfg_idx_i from cfg_data_i[2N-1:0]. A write with cfg_plane_i=1 loads OR column cfg_idx_i from cfg_data_i[T-1:0]. The new content acts only after the clock edge that takes the write.
- R8: A synchronous reset clears both planes and the state. ctrl_o is then all zeros and state_o is 0 until the planes are programmed again.
- R9: While rdy_i is 1, the state loads the next-state field ctrl_o[ST_W-1:0] at each rising edge.
- R10: While rdy_i is 0, the state keeps its value.
- R11: If the next-state field is greater than LAST_STATE, the state becomes 0 at the edge (when rdy_i is 1).
- R12: state_o never exceeds LAST_STATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ir_i | input | IR_W | Instruction register value |
| status_i | input | 6 | Status flags (negative, overflow, zero, carry, interrupt mask, decimal) |
| irq_i | input | 1 | Maskable interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt request |
| rdy_i | input | 1 | Memory ready; when low, the sequencer is held |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_plane_i | input | 1 | 0 selects an AND-plane row, 1 selects an OR-plane column |
| cfg_idx_i | input | IDX_W | Row or column index |
| cfg_data_i | input | CFG_W | Row mask or column mask |
| ctrl_o | output | NUM_OUT | Control lines; bits ST_W-1:0 are the next-state field |
| state_o | output | ST_W | Present machine cycle |

## Verification
The bench sweeps every combination of a reduced instruction register, all flags and both interrupt lines. It compares each control line with a sum-of-products value that it computes itself. An empty term that read as 0, or a contradictory term that read as 1, would show up at once on the lines that carry those terms. The sequencer is walked through every cycle, including the step whose next-state field goes past the last defined cycle; a design without that recovery would stick in an undefined state. The bench also checks that the state holds while ready is low, that a plane write acts one edge late and not at once, and that a reset in mid-run leaves every control line at zero.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // Flag inputs: negative, overflow, zero, carry, interrupt mask, decimal
    localparam int STATUS_W = 6;
    // Side inputs: irq, nmi, rdy
    localparam int SIDE_W = 3;

    typedef enum logic {
        PLANE_AND = 1'b0,
        PLANE_OR  = 1'b1
    } plane_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int NUM_IN    = 21,
    parameter int NUM_TERMS = 32,
    localparam int LINE_W   = 2 * NUM_IN
) (
    input  logic [NUM_IN-1:0]                 in_i,
    input  logic [NUM_TERMS-1:0][LINE_W-1:0]  mask_i,
    output logic [NUM_TERMS-1:0]              term_o
);

    logic [LINE_W-1:0] lines;

    // Each input feeds a true line and a complemented line
    for (genvar k = 0; k < NUM_IN; k++) begin : g_lines
        assign lines[2*k]   = in_i[k];
        assign lines[2*k+1] = ~in_i[k];
    end

    // A term is 1 when every required line is 1; unrequired lines are masked in
    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_terms
        assign term_o[t] = &(lines | ~mask_i[t]);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int NUM_TERMS = 32,
    parameter int NUM_OUT   = 130
) (
    input  logic [NUM_TERMS-1:0]               term_i,
    input  logic [NUM_OUT-1:0][NUM_TERMS-1:0]  mask_i,
    output logic [NUM_OUT-1:0]                 out_o
);

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_sums
        assign out_o[j] = |(term_i & mask_i[j]);
    end

endmodule

// File: rtl/pla_seq_next.sv
module pla_seq_next #(
    parameter int ST_W       = 4,
    parameter int LAST_STATE = 6
) (
    input  logic [ST_W-1:0] cur_i,
    input  logic [ST_W-1:0] field_i,
    input  logic            rdy_i,
    output logic [ST_W-1:0] next_o
);

    localparam logic [ST_W-1:0] LAST = LAST_STATE[ST_W-1:0];

    logic [ST_W-1:0] legal;

    always_comb begin
        legal  = (field_i > LAST) ? '0 : field_i;
        next_o = rdy_i ? legal : cur_i;
    end

endmodule

// File: rtl/pla_ctrl_decoder.sv
module pla_ctrl_decoder
    import pla_pkg::*;
#(
    parameter int IR_W       = 8,
    parameter int ST_W       = 4,
    parameter int LAST_STATE = 6,
    parameter int NUM_TERMS  = 32,
    parameter int NUM_OUT    = 130,
    localparam int NUM_IN    = IR_W + ST_W + STATUS_W + SIDE_W,
    localparam int LINE_W    = 2 * NUM_IN,
    localparam int CFG_W     = max2(LINE_W, NUM_TERMS),
    localparam int IDX_W     = $clog2(max2(NUM_TERMS, NUM_OUT))
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [IR_W-1:0]     ir_i,
    input  logic [STATUS_W-1:0] status_i,
    input  logic                irq_i,
    input  logic                nmi_i,
    input  logic                rdy_i,
    input  logic                cfg_we_i,
    input  logic                cfg_plane_i,
    input  logic [IDX_W-1:0]    cfg_idx_i,
    input  logic [CFG_W-1:0]    cfg_data_i,
    output logic [NUM_OUT-1:0]  ctrl_o,
    output logic [ST_W-1:0]     state_o
);

    typedef struct packed {
        logic [NUM_TERMS-1:0][LINE_W-1:0]  and_m;
        logic [NUM_OUT-1:0][NUM_TERMS-1:0] or_m;
        logic [ST_W-1:0]                   seq;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_IN-1:0]    in_vec;
    logic [NUM_TERMS-1:0] terms;
    logic [ST_W-1:0]      seq_next;

    // Array input order: ir, state, status, irq, nmi, rdy (bit 0 upward)
    assign in_vec = {rdy_i, nmi_i, irq_i, status_i, r_q.seq, ir_i};

    pla_and_plane #(
        .NUM_IN    (NUM_IN),
        .NUM_TERMS (NUM_TERMS)
    ) and_plane_i (
        .in_i   (in_vec),
        .mask_i (r_q.and_m),
        .term_o (terms)
    );

    pla_or_plane #(
        .NUM_TERMS (NUM_TERMS),
        .NUM_OUT   (NUM_OUT)
    ) or_plane_i (
        .term_i (terms),
        .mask_i (r_q.or_m),
        .out_o  (ctrl_o)
    );

    pla_seq_next #(
        .ST_W       (ST_W),
        .LAST_STATE (LAST_STATE)
    ) seq_next_i (
        .cur_i   (r_q.seq),
        .field_i (ctrl_o[ST_W-1:0]),
        .rdy_i   (rdy_i),
        .next_o  (seq_next)
    );

    always_comb begin
        r_d     = r_q;
        r_d.seq = seq_next;
        if (cfg_we_i) begin
            if (cfg_plane_i == PLANE_AND) begin
                for (int t = 0; t < NUM_TERMS; t++) begin
                    if (cfg_idx_i == t[IDX_W-1:0]) begin
                        r_d.and_m[t] = cfg_data_i[LINE_W-1:0];
                    end
                end
            end else begin
                for (int j = 0; j < NUM_OUT; j++) begin
                    if (cfg_idx_i == j[IDX_W-1:0]) begin
                        r_d.or_m[j] = cfg_data_i[NUM_TERMS-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.seq;

endmodule

// File: rtl/pla_ctrl_decoder_chk.sv
module pla_ctrl_decoder_chk #(
    parameter int ST_W       = 4,
    parameter int LAST_STATE = 6
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic            rdy_i,
    input logic [ST_W-1:0] state_i,
    input logic [ST_W-1:0] field_i
);

    localparam logic [ST_W-1:0] LAST = LAST_STATE[ST_W-1:0];

    AST_STATE_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        state_i <= LAST);                                                   // R12

    AST_HOLD_NOT_READY: assert property (@(posedge clk_i) disable iff (rst_i)
        !rdy_i |=> $stable(state_i));                                       // R10

    AST_LOAD_FIELD: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdy_i && field_i <= LAST) |=> state_i == $past(field_i));          // R9

    AST_INVALID_TO_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (rdy_i && field_i > LAST) |=> state_i == '0);                       // R11

endmodule

bind pla_ctrl_decoder pla_ctrl_decoder_chk #(
    .ST_W       (ST_W),
    .LAST_STATE (LAST_STATE)
) chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .rdy_i   (rdy_i),
    .state_i (state_o),
    .field_i (ctrl_o[ST_W-1:0])
);

// File: tb/pla_ctrl_decoder_tb.sv
`timescale 1ns/1ps
module pla_ctrl_decoder_tb_top;

    localparam int IR_W = 4;
    localparam int ST_W = 3;
    localparam int LAST = 5;
    localparam int NT   = 10;
    localparam int NO   = 12;
    localparam int NIN  = IR_W + ST_W + 6 + 3;
    localparam int LW   = 2 * NIN;
    localparam int CW   = 32;
    localparam int IW   = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [IR_W-1:0] ir = '0;
    logic [5:0]      sts = '0;
    logic            irq = 1'b0;
    logic            nmi = 1'b0;
    logic            rdy = 1'b0;
    logic            cfg_we = 1'b0;
    logic            cfg_plane = 1'b0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [CW-1:0]   cfg_data = '0;
    logic [NO-1:0]   ctrl;
    logic [ST_W-1:0] state;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [LW-1:0] am [NT];
    logic [NT-1:0] om [NO];

    pla_ctrl_decoder #(
        .IR_W       (IR_W),
        .ST_W       (ST_W),
        .LAST_STATE (LAST),
        .NUM_TERMS  (NT),
        .NUM_OUT    (NO)
    ) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .ir_i        (ir),
        .status_i    (sts),
        .irq_i       (irq),
        .nmi_i       (nmi),
        .rdy_i       (rdy),
        .cfg_we_i    (cfg_we),
        .cfg_plane_i (cfg_plane),
        .cfg_idx_i   (cfg_idx),
        .cfg_data_i  (cfg_data),
        .ctrl_o      (ctrl),
        .state_o     (state)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Sum-of-products value from the requirement encoding (R1, R2, R5)
    function automatic logic [NO-1:0] model(input logic [ST_W-1:0] st);
        logic [NIN-1:0] v;
        logic [NT-1:0]  tv;
        logic [NO-1:0]  o;
        v = {rdy, nmi, irq, sts, st, ir};
        for (int t = 0; t < NT; t++) begin
            tv[t] = 1'b1;
            for (int k = 0; k < NIN; k++) begin
                if (am[t][2*k] && !v[k])   tv[t] = 1'b0;
                if (am[t][2*k+1] && v[k])  tv[t] = 1'b0;
            end
        end
        for (int j = 0; j < NO; j++) o[j] = |(tv & om[j]);
        return o;
    endfunction

    function automatic int fnext(input int s);
        return (s < LAST) ? s + 1 : 7;
    endfunction

    task automatic cfg_write(input logic pl, input int idx, input logic [CW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_plane = pl; cfg_idx = idx[IW-1:0]; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (!pl) am[idx] = d[LW-1:0];
        else     om[idx] = d[NT-1:0];
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [CW-1:0]   w;
        logic [NO-1:0]   e;
        logic [ST_W-1:0] exp_st;
        logic [ST_W-1:0] field;
        for (int t = 0; t < NT; t++) am[t] = '0;
        for (int j = 0; j < NO; j++) om[j] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: cleared planes give all-zero controls and state 0
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            ir = a[3:0]; sts = {a[5:4], a[3:0]}; irq = a[1]; nmi = a[2];
            #1;
            check("R8 ctrl after reset", 64'(ctrl), 64'(0));
            check("R8 state after reset", 64'(state), 64'(0));
        end

        // Terms 0..5 decode state s exactly (state is inputs 4..6)
        for (int s = 0; s <= LAST; s++) begin
            w = '0;
            for (int b = 0; b < ST_W; b++) begin
                if (((s >> b) & 1) != 0) w[2*(4+b)] = 1'b1;
                else                     w[2*(4+b)+1] = 1'b1;
            end
            cfg_write(1'b0, s, w);
        end
        cfg_write(1'b0, 6, '0);                                    // empty term
        w = '0; w[26] = 1'b1; w[27] = 1'b1;                        // irq both ways
        cfg_write(1'b0, 7, w);
        w = '0; w[0] = 1'b1; w[27] = 1'b1; w[18] = 1'b1;           // ir0 & !irq & status2
        cfg_write(1'b0, 8, w);
        w = '0; w[7] = 1'b1; w[28] = 1'b1; w[30] = 1'b1;           // !ir3 & nmi & rdy
        cfg_write(1'b0, 9, w);
        for (int b = 0; b < ST_W; b++) begin
            w = '0;
            for (int s = 0; s <= LAST; s++)
                if (((fnext(s) >> b) & 1) != 0) w[s] = 1'b1;
            cfg_write(1'b1, b, w);
        end
        cfg_write(1'b1, 3, 32'(1 << 6));
        cfg_write(1'b1, 4, 32'(1 << 7));
        cfg_write(1'b1, 5, 32'(1 << 8));
        cfg_write(1'b1, 6, 32'(1 << 9));
        cfg_write(1'b1, 7, 32'((1 << 8) | (1 << 9)));
        cfg_write(1'b1, 8, 32'((1 << 2) | (1 << 8)));
        cfg_write(1'b1, 9, 32'((1 << 0) | (1 << 9)));
        cfg_write(1'b1, 10, 32'((1 << NT) - 1));

        // Full sweep with rdy low, state 0
        for (int a = 0; a < 4096; a++) begin
            @(negedge clk);
            ir = a[3:0]; sts = a[9:4]; irq = a[10]; nmi = a[11];
            #1;
            e = model(3'd0);
            check("R1/R2/R5/R6 sweep", 64'(ctrl), 64'(e));
            check("R3 empty term", 64'(ctrl[3]), 64'(1));
            check("R4 contradictory term", 64'(ctrl[4]), 64'(0));
        end
        check("R10 held during sweep", 64'(state), 64'(0));

        // Sequencer walk with rdy high
        exp_st = '0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            rdy = 1'b1; ir = c[3:0]; sts = 6'(c * 7); irq = c[0]; nmi = c[1];
            #1;
            e = model(exp_st);
            check("R6 mealy walk", 64'(ctrl), 64'(e));
            check("R9/R11 state walk", 64'(state), 64'(exp_st));
            check("R12 state range", 64'(state <= LAST), 64'(1));
            field  = e[ST_W-1:0];
            exp_st = (field > LAST) ? '0 : field;
        end

        // R10: hold with rdy low
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            rdy = 1'b0; ir = 4'(c + 3); nmi = ~nmi;
            #1;
            check("R10 hold state", 64'(state), 64'(exp_st));
            check("R10 ctrl", 64'(ctrl), 64'(model(exp_st)));
        end

        // R7: write acts only after the edge
        @(negedge clk);
        irq = 1'b0;
        cfg_we = 1'b1; cfg_plane = 1'b0; cfg_idx = 4'd6; cfg_data = 32'(1 << 26);
        #1;
        check("R7 before edge", 64'(ctrl[3]), 64'(1));
        @(negedge clk);
        cfg_we = 1'b0;
        am[6] = LW'(1 << 26);
        #1;
        check("R7 after edge irq0", 64'(ctrl[3]), 64'(0));
        @(negedge clk);
        irq = 1'b1;
        #1;
        check("R7 after edge irq1", 64'(ctrl[3]), 64'(1));
        cfg_write(1'b1, 11, 32'(1 << 6));
        #1;
        check("R7 OR column write", 64'(ctrl[11]), 64'(1));
        check("R7 full vector", 64'(ctrl), 64'(model(exp_st)));

        // R8: reset in mid-run
        @(negedge clk);
        rst = 1'b1; rdy = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int t = 0; t < NT; t++) am[t] = '0;
        for (int j = 0; j < NO; j++) om[j] = '0;
        for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            ir = a[3:0]; irq = a[4]; sts = 6'(a * 5);
            #1;
            check("R8 ctrl after mid reset", 64'(ctrl), 64'(0));
            check("R8 state after mid reset", 64'(state), 64'(0));
        end

        report();
    end

endmodule